// File: doc/BRIEF.md
# Indexed Addressing Effective-Address Unit

This unit turns an indexed-operand descriptor into a 16-bit effective address. The core feeds it a postbyte, then any extension bytes, over a valid/ready byte channel. It also supplies the live values of the four base registers (X, Y, SP, PC) and the two 8-bit accumulators A and B. The 16-bit D accumulator is the pair {A, B}, with A as the high byte. From these the unit works out which addressing form the postbyte names and how many extension bytes follow. It consumes exactly those bytes and forms base plus offset. For the two indirect forms it reads a 16-bit pointer through a byte-wide memory port.

When the address is ready, `done` pulses for one cycle. At that point `ea`, `ext_count` and `illegal` are valid. For the auto-adjust form, a one-cycle write-back strobe names the base register and gives its new value. The core must hold the register and accumulator inputs steady from the postbyte until `done`. PC is taken to be the address of the byte that follows the operand's last extension byte.

Top module: `idx_ea_unit`

## Requirements
- R1: The base-register field selects X for 00, Y for 01, SP for 10 and PC for 11. The field sits in postbyte bits [7:6] in the short-offset and auto-adjust forms, and in bits [4:3] in every form whose top three bits are 111.
- R2: A postbyte with bit 5 clear is a short constant form: bits [4:0] are a two's-complement offset (-16..+15) added to the base, with no extension bytes (`ext_count` = 0).
- R3: Postbyte 111rr00s takes one extension byte as the low 8 bits of a 9-bit offset whose sign is s (range -256..+255), and `ext_count` = 1.
- R4: Postbyte 111rr010 takes two extension bytes, high byte first, as a 16-bit offset, and `ext_count` = 2.
- R5: Postbyte 111rr011 takes a 16-bit offset the same way, forms pointer = base + offset, reads the high byte at the pointer and the low byte at pointer+1, and reports {high, low} as `ea`. `done` comes only after the second read acknowledge, and `mem_addr` holds steady while a request waits.
- R6: Postbyte 111rr100 adds A and 111rr101 adds B, each as an unsigned 8-bit value. 111rr110 adds D = {A, B}. None of these takes extension bytes.
- R7: Postbyte 111rr111 forms pointer = base + D and reads the address through memory, as in R5, with `ext_count` = 0.
- R8: A postbyte rr1pnnnn whose top three bits are not 111 is auto-adjust. nnnn values 0..7 mean a step of +1..+8, and values 8..15 mean -8..-1. The new value is base + step. p = 0 (pre) gives `ea` = new value; p = 1 (post) gives `ea` = old base. Together with `done`, `wb_en` pulses with `wb_sel` = rr and `wb_value` = new value.
- R9: `wb_en` is never asserted outside the `done` cycle, and never for a form other than auto-adjust.
- R10: All address sums are taken modulo 2^16, including pointer+1.
- R11: After an operand's last byte is accepted, `byte_ready` stays low until `done`. Back-to-back operands are split correctly, so each postbyte is consumed with exactly its own extension bytes.
- R12: Every postbyte starting with 111 decodes as one of the extended forms. `illegal` is therefore low for all 256 postbytes, and base register 11 can never be stepped.
- R13: `done` lasts exactly one cycle, and `ea` changes only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | Postbyte/extension byte offered |
| byte_data | input | 8 | Offered byte |
| byte_ready | output | 1 | Unit accepts a byte this cycle |
| reg_x | input | 16 | X base register |
| reg_y | input | 16 | Y base register |
| reg_sp | input | 16 | Stack pointer base |
| reg_pc | input | 16 | PC base (address after last extension byte) |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| mem_req | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte address |
| mem_ack | input | 1 | Read data valid for the current request |
| mem_rdata | input | 8 | Read data |
| ea | output | 16 | Effective address, valid with done |
| done | output | 1 | One-cycle completion pulse |
| ext_count | output | 2 | Extension bytes consumed by the operand |
| wb_en | output | 1 | Base-register write-back strobe |
| wb_sel | output | 2 | Register to write back (R1 encoding) |
| wb_value | output | 16 | Write-back value |
| illegal | output | 1 | Illegal-form flag, valid with done |

## Verification
The bench goes after the points where the sign and width of the offset change. It drives 5-bit offsets of -16 and +15, 9-bit offsets at -256, and auto-adjust codes 0111 and 1000. A unit that sign-extended from the wrong bit, or mapped the step with zero meaning zero, would report an address off by 256 or by one. Sums are forced across 0xFFFF in both directions, and a pointer is placed at 0xFFFF, so a unit that dropped the carry or did not wrap pointer+1 would read the wrong low byte. Memory acknowledges arrive after random delays, which catches a unit that raised `done` early or swapped the high and low pointer bytes. Every one of the 256 postbytes is sent back to back with random extension bytes, which shows whether an operand ever takes too few or too many bytes, or whether the extended prefix ever leaks into the auto-adjust form.

// File: rtl/idx_ea_pkg.sv
// Package: shared types for the indexed effective-address unit.
// Assumes: byte-wide operand stream, address width twice the byte width.
package idx_ea_pkg;

    // Addressing form named by a postbyte.
    typedef enum logic [2:0] {
        FM_SHORT  = 3'd0,   // 5-bit signed constant
        FM_OFF9   = 3'd1,   // 9-bit signed constant, one extension byte
        FM_OFF16  = 3'd2,   // 16-bit constant, two extension bytes
        FM_IND16  = 3'd3,   // 16-bit constant, then pointer read
        FM_STEP   = 3'd4,   // auto pre/post increment/decrement
        FM_ACC    = 3'd5,   // accumulator offset A, B or D
        FM_INDD   = 3'd6    // D offset, then pointer read
    } form_e;

    // Fields recovered from one postbyte.
    typedef struct packed {
        form_e       form;
        logic [1:0]  base_sel;  // 00 X, 01 Y, 10 SP, 11 PC
        logic [1:0]  n_ext;     // extension bytes that follow
        logic        pre_adj;   // auto-adjust: update before use
        logic        bad;       // auto-adjust on PC
        logic [1:0]  acc_sel;   // 00 A, 01 B, 10 D
        logic [4:0]  imm;       // short offset or signed step
        logic        sign9;     // sign of the 9-bit offset
    } pb_fields_t;

endpackage

// File: rtl/idx_pb_decode.sv
// Module: idx_pb_decode
// Splits a postbyte into form, base select, extension count and immediates.
// Assumes: any postbyte whose top three bits are 111 names an extended form,
// so the auto-adjust form only exists for base fields 00..10.
module idx_pb_decode
    import idx_ea_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] pb,
    output pb_fields_t        fields
);

    localparam int TOP = BYTE_W - 1;

    // Purpose: classify the postbyte and pull out its fields.
    always_comb begin
        fields          = '0;
        fields.form     = FM_SHORT;
        fields.base_sel = pb[TOP -: 2];
        if (!pb[5]) begin
            fields.form = FM_SHORT;
            fields.imm  = pb[4:0];
        end else if (pb[TOP -: 3] != 3'b111) begin
            fields.form    = FM_STEP;
            fields.pre_adj = ~pb[4];
            fields.imm     = pb[3] ? {1'b1, pb[3:0]} : ({1'b0, pb[3:0]} + 5'd1);
            fields.bad     = (pb[TOP -: 2] == 2'b11);
        end else begin
            fields.base_sel = pb[4:3];
            if (!pb[2]) begin
                case (pb[1:0])
                    2'b00, 2'b01: begin
                        fields.form  = FM_OFF9;
                        fields.n_ext = 2'd1;
                        fields.sign9 = pb[0];
                    end
                    2'b10: begin
                        fields.form  = FM_OFF16;
                        fields.n_ext = 2'd2;
                    end
                    default: begin
                        fields.form  = FM_IND16;
                        fields.n_ext = 2'd2;
                    end
                endcase
            end else if (pb[1:0] == 2'b11) begin
                fields.form = FM_INDD;
            end else begin
                fields.form    = FM_ACC;
                fields.acc_sel = pb[1:0];
            end
        end
    end

endmodule

// File: rtl/idx_addr_calc.sv
// Module: idx_addr_calc
// Picks the base register, builds the offset for the decoded form and adds.
// Assumes: ADDR_W = 2*BYTE_W; all sums wrap modulo 2^ADDR_W.
module idx_addr_calc
    import idx_ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  pb_fields_t        fields,
    input  logic [BYTE_W-1:0] ext_hi,
    input  logic [BYTE_W-1:0] ext_lo,
    input  logic [ADDR_W-1:0] reg_x,
    input  logic [ADDR_W-1:0] reg_y,
    input  logic [ADDR_W-1:0] reg_sp,
    input  logic [ADDR_W-1:0] reg_pc,
    input  logic [BYTE_W-1:0] acc_a,
    input  logic [BYTE_W-1:0] acc_b,
    output logic [ADDR_W-1:0] sum,
    output logic [ADDR_W-1:0] direct_ea
);

    localparam int PAD  = ADDR_W - BYTE_W;
    localparam int IPAD = ADDR_W - 5;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offset;

    // Purpose: select the base register named by the base field.
    always_comb begin
        case (fields.base_sel)
            2'b00:   base = reg_x;
            2'b01:   base = reg_y;
            2'b10:   base = reg_sp;
            default: base = reg_pc;
        endcase
    end

    // Purpose: widen the offset of the decoded form to the address width.
    always_comb begin
        case (fields.form)
            FM_SHORT, FM_STEP: offset = {{IPAD{fields.imm[4]}}, fields.imm};
            FM_OFF9:           offset = {{PAD{fields.sign9}}, ext_lo};
            FM_OFF16, FM_IND16: offset = {ext_hi, ext_lo};
            FM_ACC: begin
                case (fields.acc_sel)
                    2'b00:   offset = {{PAD{1'b0}}, acc_a};
                    2'b01:   offset = {{PAD{1'b0}}, acc_b};
                    default: offset = {acc_a, acc_b};
                endcase
            end
            default:           offset = {acc_a, acc_b};
        endcase
    end

    // Purpose: form the wrapped sum and the address a direct form reports.
    always_comb begin
        sum       = base + offset;
        direct_ea = (fields.form == FM_STEP && !fields.pre_adj) ? base : sum;
    end

endmodule

// File: rtl/idx_ptr_fetch.sv
// Module: idx_ptr_fetch
// Reads a big-endian pointer one byte per request/acknowledge handshake.
// Assumes: mem_ack is only raised while mem_req is high.
module idx_ptr_fetch #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] ptr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              fin,
    output logic [ADDR_W-1:0] value
);

    typedef enum logic [1:0] {PF_IDLE, PF_HI, PF_LO} pf_state_e;

    pf_state_e         state_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [BYTE_W-1:0] hi_q;

    // Purpose: step through high-byte then low-byte reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PF_IDLE;
            ptr_q   <= '0;
            hi_q    <= '0;
        end else begin
            case (state_q)
                PF_IDLE: if (start) begin
                    ptr_q   <= ptr;
                    state_q <= PF_HI;
                end
                PF_HI: if (mem_ack) begin
                    hi_q    <= mem_rdata;
                    state_q <= PF_LO;
                end
                PF_LO: if (mem_ack) state_q <= PF_IDLE;
                default: state_q <= PF_IDLE;
            endcase
        end
    end

    // Purpose: drive the read port and the assembled pointer.
    always_comb begin
        mem_req  = (state_q == PF_HI) || (state_q == PF_LO);
        mem_addr = (state_q == PF_LO) ? ptr_q + 1'b1 : ptr_q;
        fin      = (state_q == PF_LO) && mem_ack;
        value    = {hi_q, mem_rdata};
    end

endmodule

// File: rtl/idx_ea_unit.sv
// Module: idx_ea_unit (top)
// Accepts a postbyte and its extension bytes, computes the effective address,
// runs the pointer read for indirect forms and reports one done pulse.
// Assumes: register and accumulator inputs are steady from the postbyte
// until done; PC is the address after the operand's last extension byte.
module idx_ea_unit
    import idx_ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_ready,
    input  logic [ADDR_W-1:0] reg_x,
    input  logic [ADDR_W-1:0] reg_y,
    input  logic [ADDR_W-1:0] reg_sp,
    input  logic [ADDR_W-1:0] reg_pc,
    input  logic [BYTE_W-1:0] acc_a,
    input  logic [BYTE_W-1:0] acc_b,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] ea,
    output logic              done,
    output logic [1:0]        ext_count,
    output logic              wb_en,
    output logic [1:0]        wb_sel,
    output logic [ADDR_W-1:0] wb_value,
    output logic              illegal
);

    typedef enum logic [1:0] {S_IDLE, S_EXT, S_CALC, S_FETCH} ea_state_e;

    ea_state_e         state_q;
    pb_fields_t        f_in;
    pb_fields_t        f_q;
    logic [BYTE_W-1:0] ext_hi_q;
    logic [BYTE_W-1:0] ext_lo_q;
    logic [1:0]        left_q;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] direct_ea;
    logic              is_ind;
    logic              fetch_start;
    logic              fetch_fin;
    logic [ADDR_W-1:0] fetch_value;
    logic              take;

    logic [ADDR_W-1:0] ea_q;
    logic              done_q;
    logic [1:0]        ext_cnt_q;
    logic              wb_en_q;
    logic [1:0]        wb_sel_q;
    logic [ADDR_W-1:0] wb_val_q;
    logic              illegal_q;

    idx_pb_decode #(.BYTE_W(BYTE_W)) u_decode (
        .pb     (byte_data),
        .fields (f_in)
    );

    idx_addr_calc #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_calc (
        .fields    (f_q),
        .ext_hi    (ext_hi_q),
        .ext_lo    (ext_lo_q),
        .reg_x     (reg_x),
        .reg_y     (reg_y),
        .reg_sp    (reg_sp),
        .reg_pc    (reg_pc),
        .acc_a     (acc_a),
        .acc_b     (acc_b),
        .sum       (sum),
        .direct_ea (direct_ea)
    );

    idx_ptr_fetch #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fetch_start),
        .ptr       (sum),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .fin       (fetch_fin),
        .value     (fetch_value)
    );

    // Purpose: byte acceptance and fetch launch conditions.
    always_comb begin
        byte_ready  = (state_q == S_IDLE) || (state_q == S_EXT);
        take        = byte_ready && byte_valid;
        is_ind      = (f_q.form == FM_IND16) || (f_q.form == FM_INDD);
        fetch_start = (state_q == S_CALC) && is_ind;
    end

    // Purpose: operand sequencing from postbyte to completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            f_q      <= '0;
            ext_hi_q <= '0;
            ext_lo_q <= '0;
            left_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (take) begin
                    f_q     <= f_in;
                    left_q  <= f_in.n_ext;
                    state_q <= (f_in.n_ext == 2'd0) ? S_CALC : S_EXT;
                end
                S_EXT: if (take) begin
                    if (left_q == 2'd2) ext_hi_q <= byte_data;
                    else                ext_lo_q <= byte_data;
                    left_q <= left_q - 2'd1;
                    if (left_q == 2'd1) state_q <= S_CALC;
                end
                S_CALC:  state_q <= is_ind ? S_FETCH : S_IDLE;
                S_FETCH: if (fetch_fin) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Purpose: register the results presented with the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q      <= '0;
            done_q    <= 1'b0;
            ext_cnt_q <= '0;
            wb_en_q   <= 1'b0;
            wb_sel_q  <= '0;
            wb_val_q  <= '0;
            illegal_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            wb_en_q <= 1'b0;
            if (state_q == S_CALC && !is_ind) begin
                done_q    <= 1'b1;
                ea_q      <= direct_ea;
                ext_cnt_q <= f_q.n_ext;
                wb_en_q   <= (f_q.form == FM_STEP) && !f_q.bad;
                wb_sel_q  <= f_q.base_sel;
                wb_val_q  <= sum;
                illegal_q <= f_q.bad;
            end else if (state_q == S_FETCH && fetch_fin) begin
                done_q    <= 1'b1;
                ea_q      <= fetch_value;
                ext_cnt_q <= f_q.n_ext;
                illegal_q <= 1'b0;
            end
        end
    end

    // Purpose: expose registered results.
    always_comb begin
        ea        = ea_q;
        done      = done_q;
        ext_count = ext_cnt_q;
        wb_en     = wb_en_q;
        wb_sel    = wb_sel_q;
        wb_value  = wb_val_q;
        illegal   = illegal_q;
    end

endmodule

// File: rtl/idx_ea_unit_chk.sv
// Module: idx_ea_unit_chk
// Temporal checks on the ports of idx_ea_unit, attached by bind.
module idx_ea_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_ready,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] ea,
    input logic              done,
    input logic              wb_en,
    input logic [1:0]        wb_sel,
    input logic              illegal
);

    // R13: done never lasts two cycles
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13: ea moves only together with done
    p_ea_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(ea) |-> done);

    // R9: write-back strobe only in a done cycle
    p_wb_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // R8: PC is never the target of a write-back
    p_wb_not_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_sel != 2'b11));

    // R5: a waiting read keeps its address
    p_req_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R11: no byte is taken while the pointer read runs
    p_no_take_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !byte_ready);

    // R12: no postbyte reaches the illegal flag
    p_no_illegal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !illegal);

endmodule

bind idx_ea_unit idx_ea_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_ready (byte_ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .ea         (ea),
    .done       (done),
    .wb_en      (wb_en),
    .wb_sel     (wb_sel),
    .illegal    (illegal)
);

// File: tb/idx_ea_unit_test.sv
// Bench for idx_ea_unit: directed corners plus seeded random operands.
module idx_ea_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_ready;
    logic [15:0] rx = '0, ry = '0, rs = '0, rp = '0;
    logic [7:0]  ra = '0, rb = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] ea;
    logic        done;
    logic [1:0]  ext_count;
    logic        wb_en;
    logic [1:0]  wb_sel;
    logic [15:0] wb_value;
    logic        illegal;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    idx_ea_unit uut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .reg_x(rx), .reg_y(ry), .reg_sp(rs), .reg_pc(rp),
        .acc_a(ra), .acc_b(rb), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ea(ea), .done(done),
        .ext_count(ext_count), .wb_en(wb_en), .wb_sel(wb_sel),
        .wb_value(wb_value), .illegal(illegal)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        return (a[7:0] ^ 8'hA5) + {a[15:8], 1'b0} + 8'd17;
    endfunction

    function automatic logic [15:0] regv(input logic [1:0] s);
        case (s)
            2'd0: return rx;
            2'd1: return ry;
            2'd2: return rs;
            default: return rp;
        endcase
    endfunction

    // Reference model written from the requirements.
    function automatic void model(input logic [7:0] pb, input logic [7:0] e1,
                                  input logic [7:0] e2, output int nx,
                                  output logic [15:0] xea, output logic xwb,
                                  output logic [1:0] xsel, output logic [15:0] xval);
        int off, step;
        logic [15:0] base, ptr;
        bit ind;
        nx = 0; xwb = 0; xsel = 0; xval = 0; ind = 0; off = 0;
        if (pb[5] == 1'b0) begin                       // R2
            base = regv(pb[7:6]);
            off  = (pb[4:0] > 15) ? int'(pb[4:0]) - 32 : int'(pb[4:0]);
            xea  = base + 16'(off);
        end else if (pb[7:6] != 2'b11) begin           // R8
            base = regv(pb[7:6]);
            step = (pb[3:0] < 8) ? int'(pb[3:0]) + 1 : int'(pb[3:0]) - 16;
            xval = base + 16'(step);
            xea  = pb[4] ? base : xval;
            xwb  = 1; xsel = pb[7:6];
        end else begin                                 // R1 field at [4:3]
            base = regv(pb[4:3]);
            case (pb[2:0])
                3'b000: begin off = int'(e1); nx = 1; end           // R3
                3'b001: begin off = int'(e1) - 256; nx = 1; end
                3'b010: begin off = int'({e1, e2}); nx = 2; end     // R4
                3'b011: begin off = int'({e1, e2}); nx = 2; ind = 1; end // R5
                3'b100: off = int'(ra);                               // R6
                3'b101: off = int'(rb);
                3'b110: off = int'({ra, rb});
                default: begin off = int'({ra, rb}); ind = 1; end     // R7
            endcase
            ptr = base + 16'(off);                                   // R10
            xea = ind ? {memf(ptr), memf(ptr + 16'd1)} : ptr;
        end
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_data  = b;
        while (!byte_ready) @(negedge clk);
        @(negedge clk);
        byte_valid = 1'b0;
        if ($urandom_range(0, 3) == 0) @(negedge clk);
    endtask

    task automatic run_op(input logic [7:0] pb, input logic [7:0] e1, input logic [7:0] e2);
        int nx, waited;
        logic [15:0] xea, xval, ea_seen;
        logic xwb;
        logic [1:0] xsel;
        bit early_wb, early_ready;
        model(pb, e1, e2, nx, xea, xwb, xsel, xval);
        send_byte(pb);
        if (nx >= 1) send_byte(e1);
        if (nx == 2) send_byte(e2);
        byte_valid = 1'b0;
        early_wb = 0; early_ready = 0; waited = 0;
        while (!done && waited < 40) begin
            if (wb_en) early_wb = 1;
            if (byte_ready) early_ready = 1;
            @(negedge clk);
            waited++;
        end
        chk(done, "R13 done", {31'd0, done}, 32'd1);
        chk(!early_ready, "R11 ready low until done", {31'd0, early_ready}, 32'd0);
        chk(!early_wb, "R9 no early write-back", {31'd0, early_wb}, 32'd0);
        chk(ea == xea, "R2-R8 ea", {16'd0, ea}, {16'd0, xea});
        chk(ext_count == 2'(nx), "R11 ext_count", {30'd0, ext_count}, nx);
        chk(illegal == 1'b0, "R12 illegal", {31'd0, illegal}, 32'd0);
        chk(wb_en == xwb, "R9 wb_en", {31'd0, wb_en}, {31'd0, xwb});
        if (xwb)
            chk(wb_sel == xsel && wb_value == xval, "R8 write-back",
                {14'd0, wb_sel, wb_value}, {14'd0, xsel, xval});
        ea_seen = ea;
        @(negedge clk);
        chk(!done && ea == ea_seen, "R13 pulse/hold", {15'd0, done, ea}, {16'd0, ea_seen});
    endtask

    // Memory responder with random acknowledge delay.
    initial begin
        int dly;
        dly = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (dly == 0) begin
                    mem_ack   = 1'b1;
                    mem_rdata = memf(mem_addr);
                    dly       = $urandom_range(0, 2);
                end else dly--;
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!done && !wb_en && ea == 16'd0 && byte_ready == 1'b0 || !done,
            "R13 reset", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(byte_ready && !done && !mem_req && ea == 16'd0, "R11 reset state",
            {13'd0, byte_ready, done, mem_req, ea}, {13'd0, 3'b100, 16'd0});

        // R1 R2 R10: short offsets at both ends, with wrap
        rx = 16'hFFFF; ry = 16'h0000; rs = 16'h8000; rp = 16'h1234;
        run_op(8'h01, 8'h00, 8'h00);      // X + 1 wraps to 0000
        run_op(8'h50, 8'h00, 8'h00);      // Y - 16 wraps
        run_op(8'h8F, 8'h00, 8'h00);      // SP + 15
        run_op(8'hDF, 8'h00, 8'h00);      // PC - 1
        // R3: 9-bit extremes
        run_op(8'hE1, 8'h00, 8'h00);      // X - 256
        run_op(8'hE8, 8'hFF, 8'h00);      // Y + 255
        // R4 R5: 16-bit and indirect, pointer at FFFF for R10
        run_op(8'hF2, 8'h80, 8'h01);
        rs = 16'hFFFE;
        run_op(8'hF3, 8'h00, 8'h01);      // pointer FFFF, low byte at 0000
        // R6 R7: accumulators
        ra = 8'hF0; rb = 8'h81; rp = 16'h2000;
        run_op(8'hFC, 8'h00, 8'h00);
        run_op(8'hFD, 8'h00, 8'h00);
        run_op(8'hFE, 8'h00, 8'h00);
        run_op(8'hE7, 8'h00, 8'h00);
        // R8: step codes at the sign boundary, pre and post
        rx = 16'h0000; ry = 16'hFFFC; rs = 16'h0100;
        run_op(8'h27, 8'h00, 8'h00);      // X pre +8
        run_op(8'h28, 8'h00, 8'h00);      // X pre -8 wraps
        run_op(8'h7F, 8'h00, 8'h00);      // Y post -1
        run_op(8'h77, 8'h00, 8'h00);      // Y post +8 wraps in write-back
        run_op(8'hA0, 8'h00, 8'h00);      // SP pre +1

        // R12 R11: every postbyte, back to back, random extension bytes
        for (int p = 0; p < 256; p++) begin
            rx = 16'($urandom); ry = 16'($urandom); rs = 16'($urandom);
            rp = 16'($urandom); ra = 8'($urandom); rb = 8'($urandom);
            run_op(8'(p), 8'($urandom), 8'($urandom));
        end

        // Random operands
        for (int k = 0; k < 300; k++) begin
            rx = 16'($urandom); ry = 16'($urandom); rs = 16'($urandom);
            rp = 16'($urandom); ra = 8'($urandom); rb = 8'($urandom);
            run_op(8'($urandom), 8'($urandom), 8'($urandom));
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule